// File: doc/BRIEF.md
# Multi-Channel Audio Sample Receive Queue

This block sits between a set of decimation filters and a bus master. Each filter delivers 24-bit audio samples tagged with a capture channel number. The block keeps the samples of enabled channels in a small first-in first-out queue. A processor or a DMA engine drains the queue one word at a time by reading a single holding location. Each word returns the sample in its low 24 bits and the channel number in its top byte, so the reader can sort interleaved channels.

Queue conditions and two error events are collected in a status word that is cleared when it is read. Interrupt enable bits are set and cleared through two separate write-one locations, so a set or clear needs no read-modify-write. The interrupt line is the OR of the latched status bits that are enabled. A software reset flushes the queue. A DMA burst threshold in the mode word sets how many queued words raise the chunk flag. The mode and configuration words are also driven out to the front-end logic that samples the microphones.

The bus is 32 bits wide and word addressed. Each location's word index is its byte offset divided by four. A read returns its data one clock after the request.

Top module: `mic_rx_queue`

## Requirements
- R1: After reset the queue is empty, the mode, configuration and interrupt enable words are 0, `bus_rdata` is 0 and `irq` is low. The first status read returns only the empty flag (0x2).
- R2: Writes to the mode word (word 1, byte 0x04) and the configuration word (word 2, byte 0x08) are read back unchanged and appear on `mode_word` and `cfg_word`.
- R3: A sample is queued only when bit N of the mode word is 1, where N is its channel. A sample from a disabled channel leaves the queue and the status unchanged.
- R4: Reading the holding location (word 3, byte 0x0C) returns `{channel zero-extended to 8 bits, sample[23:0]}` for the oldest entry and removes it. Entries come out in arrival order.
- R5: Reading the holding location while the queue is empty returns 0 and latches the underrun flag (status bit 4).
- R6: A sample that arrives while the queue holds DEPTH words is dropped and latches the overrun flag (bit 5). This does not apply when a holding read in the same cycle frees a slot; the sample is then accepted.
- R7: The status bits are: bit 0 ready (at least one word queued), bit 1 empty, bit 2 full (DEPTH words), bit 3 chunk. The chunk flag is set when the queued count is at least the threshold coded in mode bits [31:28]. Codes 1, 2, 4 and 8 give that many words; any other code gives 1.
- R8: A status read (word 8, byte 0x20) returns every flag seen since the previous status read, then clears the latched word. Level conditions that are still true appear again at the next read. An underrun or overrun in the same cycle as the read is reported by that read and not by the next one.
- R9: Writing 1 to a bit at word 5 (byte 0x14) sets that enable bit. Writing 1 at word 6 (byte 0x18) clears it. Zero bits have no effect. The enables read back at word 7 (byte 0x1C), and writes there are ignored.
- R10: `irq` is high whenever a latched status bit and its enable bit are both 1. It rises one clock after the flag latches and stays high until a status read clears the flag.
- R11: Writing 1 to bit 0 of word 0 (byte 0x00) empties the queue and clears the latched status. The mode, configuration and enable words keep their values.
- R12: Word 20 (byte 0x50) returns the VERSION parameter in bits [11:0] with the upper bits 0, and writes there are ignored. Unmapped and write-only locations read as 0.
- R13: Read data appears on `bus_rdata` the cycle after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe from the decimators |
| smp_chan | input | 2 | Channel number of the sample |
| smp_data | input | 24 | Sample value |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| mode_word | output | 32 | Current mode word |
| cfg_word | output | 32 | Current configuration word |
| irq | output | 1 | Level interrupt |

## Verification
Three latencies matter, and each check samples on the falling edge where its result is due.

- **Read data:** a read request is taken at one rising edge, and its data is sampled on the falling edge that follows.
- **Status:** a status read returns the live conditions together with the latched bits, so it already sees a push or pop taken at the edge just before it.
- **Interrupt:** `irq` depends only on the latched status bits. A queue condition caused by a push therefore shows on `irq` one full cycle after the push. An underrun or overrun event shows on `irq` right after the edge where it happens.

Two cases need inputs driven in the same cycle: a push together with a holding read on a full queue, and an overrun together with a status read. The bench drives both in one cycle and checks the result on the following falling edge.

// File: rtl/mic_rx_pkg.sv
`timescale 1ns/1ps
package mic_rx_pkg;

  localparam int unsigned BUS_AW = 5;

  // word addresses (byte offset / 4)
  localparam logic [BUS_AW-1:0] WA_CTRL = 5'd0;
  localparam logic [BUS_AW-1:0] WA_MODE = 5'd1;
  localparam logic [BUS_AW-1:0] WA_CFG  = 5'd2;
  localparam logic [BUS_AW-1:0] WA_HOLD = 5'd3;
  localparam logic [BUS_AW-1:0] WA_IEN  = 5'd5;
  localparam logic [BUS_AW-1:0] WA_IDIS = 5'd6;
  localparam logic [BUS_AW-1:0] WA_MASK = 5'd7;
  localparam logic [BUS_AW-1:0] WA_STAT = 5'd8;
  localparam logic [BUS_AW-1:0] WA_VER  = 5'd20;

  localparam int unsigned NFLAG    = 6;
  localparam int unsigned FL_READY = 0;
  localparam int unsigned FL_EMPTY = 1;
  localparam int unsigned FL_FULL  = 2;
  localparam int unsigned FL_CHUNK = 3;
  localparam int unsigned FL_UDR   = 4;
  localparam int unsigned FL_OVR   = 5;

  // flags that track a live queue condition; the rest are one-cycle events
  localparam logic [NFLAG-1:0] LEVEL_FLAGS = 6'b00_1111;

  localparam int unsigned CHUNK_LSB = 28;
  localparam int unsigned CHUNK_W   = 4;

  typedef struct packed {
    logic hold_rd;
    logic stat_rd;
    logic ctrl_rst;
    logic ien_wr;
    logic idis_wr;
  } mrq_strobe_t;

  function automatic logic [CHUNK_W-1:0] chunk_words(input logic [CHUNK_W-1:0] code);
    case (code)
      4'd1, 4'd2, 4'd4, 4'd8: chunk_words = code;
      default:                chunk_words = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/mrq_fifo.sv
`timescale 1ns/1ps
module mrq_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic                         pop,
  input  logic [WIDTH-1:0]             din,
  output logic [WIDTH-1:0]             head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         is_empty,
  output logic                         is_full,
  output logic                         drop_evt,
  output logic                         under_evt
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);
  localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DEPTH-1:0] slot_we;
  logic             do_push, do_pop;

  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == FULLC);
  assign do_pop   = pop && !is_empty;
  assign do_push  = push && (!is_full || do_pop);
  assign drop_evt = push && is_full && !do_pop;
  assign under_evt = pop && is_empty;
  assign head     = mem[rd_q];
  assign count    = cnt_q;

  always_comb begin
    wr_n    = wr_q;
    rd_n    = rd_q;
    cnt_n   = cnt_q;
    slot_we = '0;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) begin
        slot_we[wr_q] = 1'b1;
        wr_n = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) begin
        rd_n = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      end
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  // data slots carry no reset; only the written slot is enabled
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) mem[i] <= din;
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULLC);

  // R6
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && is_full && !pop && !flush) |=> (cnt_q == FULLC));

  // R5
  underrun_keeps_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && is_empty && !push && !flush) |=> (cnt_q == '0));

endmodule

// File: rtl/mrq_status.sv
`timescale 1ns/1ps
module mrq_status
  import mic_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] cond,
  input  logic             rd_clr,
  input  logic             sw_clr,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] wbits,
  output logic [NFLAG-1:0] view,
  output logic [NFLAG-1:0] mask,
  output logic             irq
);

  logic [NFLAG-1:0] stat_q, stat_n;
  logic [NFLAG-1:0] mask_q, mask_n;

  always_comb begin
    mask_n = mask_q;
    if (set_we)      mask_n = mask_q | wbits;
    else if (clr_we) mask_n = mask_q & ~wbits;
  end

  always_comb begin
    if (sw_clr)      stat_n = '0;
    else if (rd_clr) stat_n = cond & LEVEL_FLAGS;
    else             stat_n = stat_q | cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_n;
      mask_q <= mask_n;
    end
  end

  assign view = stat_q | cond;
  assign mask = mask_q;
  assign irq  = |(stat_q & mask_q);

  // R9
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask_q & $past(wbits)) == $past(wbits)));

  // R9
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((mask_q & $past(wbits)) == '0));

  // R8
  read_drops_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !sw_clr) |=> ((stat_q & ~LEVEL_FLAGS) == '0));

  // R10
  event_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(cond & mask_q & ~LEVEL_FLAGS)) && !rd_clr && !sw_clr && !clr_we) |=> irq);

  // R11
  swclr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> (stat_q == '0));

endmodule

// File: rtl/mrq_regs.sv
`timescale 1ns/1ps
module mrq_regs
  import mic_rx_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter logic [11:0] VERSION = 12'h1A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] hold_word,
  input  logic [NFLAG-1:0]  stat_view,
  input  logic [NFLAG-1:0]  mask,
  output mrq_strobe_t       strb,
  output logic [WORD_W-1:0] mode_q,
  output logic [WORD_W-1:0] cfg_q,
  output logic [WORD_W-1:0] bus_rdata
);

  logic              rd_req, wr_req;
  logic [WORD_W-1:0] mode_n, cfg_n, rdata_q, rdata_n, rd_mux;

  assign rd_req = bus_sel && !bus_wr;
  assign wr_req = bus_sel && bus_wr;

  always_comb begin
    strb          = '0;
    strb.hold_rd  = rd_req && (bus_addr == WA_HOLD);
    strb.stat_rd  = rd_req && (bus_addr == WA_STAT);
    strb.ctrl_rst = wr_req && (bus_addr == WA_CTRL) && bus_wdata[0];
    strb.ien_wr   = wr_req && (bus_addr == WA_IEN);
    strb.idis_wr  = wr_req && (bus_addr == WA_IDIS);
  end

  always_comb begin
    case (bus_addr)
      WA_MODE: rd_mux = mode_q;
      WA_CFG:  rd_mux = cfg_q;
      WA_HOLD: rd_mux = hold_word;
      WA_MASK: rd_mux = WORD_W'(mask);
      WA_STAT: rd_mux = WORD_W'(stat_view);
      WA_VER:  rd_mux = WORD_W'(VERSION);
      default: rd_mux = '0;
    endcase
  end

  always_comb begin
    mode_n  = (wr_req && bus_addr == WA_MODE) ? bus_wdata : mode_q;
    cfg_n   = (wr_req && bus_addr == WA_CFG)  ? bus_wdata : cfg_q;
    rdata_n = rd_req ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      cfg_q   <= '0;
      rdata_q <= '0;
    end else begin
      mode_q  <= mode_n;
      cfg_q   <= cfg_n;
      rdata_q <= rdata_n;
    end
  end

  assign bus_rdata = rdata_q;

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(bus_rdata));

  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bus_addr == WA_MODE) |=> (mode_q == $past(bus_wdata)));

endmodule

// File: rtl/mic_rx_queue.sv
`timescale 1ns/1ps
module mic_rx_queue
  import mic_rx_pkg::*;
#(
  parameter int unsigned NCH     = 4,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned SMP_W   = 24,
  parameter logic [11:0] VERSION = 12'h1A5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic [$clog2(NCH)-1:0]   smp_chan,
  input  logic [SMP_W-1:0]         smp_data,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [BUS_AW-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic [31:0]              mode_word,
  output logic [31:0]              cfg_word,
  output logic                     irq
);

  localparam int unsigned WORD_W = 32;
  localparam int unsigned CH_W   = $clog2(NCH);
  localparam int unsigned TAG_W  = WORD_W - SMP_W;
  localparam int unsigned CNT_W  = $clog2(DEPTH+1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mrq_strobe_t       strb;
  logic [WORD_W-1:0] mode_q, cfg_q, push_word, head, hold_word;
  logic [CNT_W-1:0]  count;
  logic              q_empty, q_full, drop_evt, under_evt, push_req;
  logic [NFLAG-1:0]  cond, stat_view, mask;
  logic [CHUNK_W-1:0] chunk_thr;

  assign push_req  = smp_valid && mode_q[smp_chan];
  assign push_word = {TAG_W'(smp_chan), smp_data};
  assign hold_word = q_empty ? '0 : head;
  assign chunk_thr = chunk_words(mode_q[CHUNK_LSB +: CHUNK_W]);

  always_comb begin
    cond           = '0;
    cond[FL_READY] = !q_empty;
    cond[FL_EMPTY] = q_empty;
    cond[FL_FULL]  = q_full;
    cond[FL_CHUNK] = (int'(count) >= int'(chunk_thr));
    cond[FL_UDR]   = under_evt;
    cond[FL_OVR]   = drop_evt;
  end

  mrq_fifo #(
    .DEPTH (DEPTH),
    .WIDTH (WORD_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .flush     (strb.ctrl_rst),
    .push      (push_req),
    .pop       (strb.hold_rd),
    .din       (push_word),
    .head      (head),
    .count     (count),
    .is_empty  (q_empty),
    .is_full   (q_full),
    .drop_evt  (drop_evt),
    .under_evt (under_evt)
  );

  mrq_status u_status (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cond   (cond),
    .rd_clr (strb.stat_rd),
    .sw_clr (strb.ctrl_rst),
    .set_we (strb.ien_wr),
    .clr_we (strb.idis_wr),
    .wbits  (bus_wdata[NFLAG-1:0]),
    .view   (stat_view),
    .mask   (mask),
    .irq    (irq)
  );

  mrq_regs #(
    .WORD_W  (WORD_W),
    .VERSION (VERSION)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hold_word (hold_word),
    .stat_view (stat_view),
    .mask      (mask),
    .strb      (strb),
    .mode_q    (mode_q),
    .cfg_q     (cfg_q),
    .bus_rdata (bus_rdata)
  );

  assign mode_word = mode_q;
  assign cfg_word  = cfg_q;

  // R3
  disabled_chan_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (smp_valid && !mode_q[smp_chan] && !strb.hold_rd && !strb.ctrl_rst) |=> $stable(count));

  // R11
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    strb.ctrl_rst |=> (count == '0));

endmodule

// File: tb/mic_rx_queue_tb.sv
`timescale 1ns/1ps
module mic_rx_queue_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [1:0]  smp_chan;
  logic [23:0] smp_data;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, mode_word, cfg_word;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mic_rx_queue u_dut (
    .clk (clk), .rst_n (rst_n),
    .smp_valid (smp_valid), .smp_chan (smp_chan), .smp_data (smp_data),
    .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .mode_word (mode_word), .cfg_word (cfg_word), .irq (irq)
  );

  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_P = 2'd2;
  localparam logic [4:0] A_CTRL = 5'd0, A_MODE = 5'd1, A_CFG = 5'd2, A_HOLD = 5'd3,
                         A_IEN = 5'd5, A_IDIS = 5'd6, A_MASK = 5'd7, A_STAT = 5'd8,
                         A_VER = 5'd20;

  // {tag[23:0], op[1:0], addr[4:0], data[31:0], expect[31:0]}
  function automatic logic [94:0] vec(input logic [23:0] tag, input logic [1:0] op,
                                      input logic [4:0] a, input logic [31:0] d,
                                      input logic [31:0] e);
    vec = {tag, op, a, d, e};
  endfunction

  localparam int NV = 48;
  localparam logic [94:0] VEC [NV] = '{
    vec("R12", OP_R, A_VER,  0, 32'h0000_01A5),
    vec("R12", OP_W, A_VER,  32'h0000_0FFF, 0),
    vec("R12", OP_R, A_VER,  0, 32'h0000_01A5),
    vec("R1 ", OP_R, A_STAT, 0, 32'h0000_0002),
    vec("R2 ", OP_W, A_MODE, 32'h4000_000F, 0),
    vec("R2 ", OP_R, A_MODE, 0, 32'h4000_000F),
    vec("R2 ", OP_W, A_CFG,  32'h00A5_0055, 0),
    vec("R2 ", OP_R, A_CFG,  0, 32'h00A5_0055),
    vec("R3 ", OP_P, 0,      32'h0112_3456, 0),
    vec("R3 ", OP_P, 0,      32'h03AB_CDEF, 0),
    vec("R3 ", OP_P, 0,      32'h0000_0001, 0),
    vec("R8 ", OP_R, A_STAT, 0, 32'h0000_0003),
    vec("R8 ", OP_R, A_STAT, 0, 32'h0000_0001),
    vec("R3 ", OP_P, 0,      32'h0277_7777, 0),
    vec("R7 ", OP_R, A_STAT, 0, 32'h0000_0009),
    vec("R4 ", OP_R, A_HOLD, 0, 32'h0112_3456),
    vec("R4 ", OP_R, A_HOLD, 0, 32'h03AB_CDEF),
    vec("R4 ", OP_R, A_HOLD, 0, 32'h0000_0001),
    vec("R4 ", OP_R, A_HOLD, 0, 32'h0277_7777),
    vec("R5 ", OP_R, A_HOLD, 0, 32'h0000_0000),
    vec("R5 ", OP_R, A_STAT, 0, 32'h0000_001B),
    vec("R8 ", OP_R, A_STAT, 0, 32'h0000_0002),
    vec("R3 ", OP_W, A_MODE, 32'h0000_0005, 0),
    vec("R3 ", OP_P, 0,      32'h0111_1111, 0),
    vec("R3 ", OP_R, A_STAT, 0, 32'h0000_0002),
    vec("R3 ", OP_P, 0,      32'h0222_2222, 0),
    vec("R7 ", OP_R, A_STAT, 0, 32'h0000_000B),
    vec("R9 ", OP_W, A_IEN,  32'h0000_0030, 0),
    vec("R9 ", OP_W, A_IEN,  32'h0000_0001, 0),
    vec("R9 ", OP_R, A_MASK, 0, 32'h0000_0031),
    vec("R9 ", OP_W, A_IDIS, 32'h0000_0010, 0),
    vec("R9 ", OP_R, A_MASK, 0, 32'h0000_0021),
    vec("R9 ", OP_W, A_IDIS, 32'h0000_0000, 0),
    vec("R9 ", OP_R, A_MASK, 0, 32'h0000_0021),
    vec("R9 ", OP_W, A_MASK, 32'h0000_00FF, 0),
    vec("R9 ", OP_R, A_MASK, 0, 32'h0000_0021),
    vec("R7 ", OP_P, 0,      32'h0000_0333, 0),
    vec("R7 ", OP_W, A_MODE, 32'h3000_0005, 0),
    vec("R7 ", OP_R, A_STAT, 0, 32'h0000_0009),
    vec("R7 ", OP_R, A_STAT, 0, 32'h0000_0009),
    vec("R7 ", OP_W, A_MODE, 32'h8000_0005, 0),
    vec("R7 ", OP_R, A_STAT, 0, 32'h0000_0009),
    vec("R7 ", OP_R, A_STAT, 0, 32'h0000_0001),
    vec("R11", OP_W, A_CTRL, 32'h0000_0001, 0),
    vec("R11", OP_R, A_STAT, 0, 32'h0000_0002),
    vec("R11", OP_R, A_MODE, 0, 32'h8000_0005),
    vec("R11", OP_R, A_MASK, 0, 32'h0000_0021),
    vec("R11", OP_R, A_HOLD, 0, 32'h0000_0000)
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // every task is entered on a falling edge and leaves on the next one
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [1:0] ch, input logic [23:0] d);
    smp_valid = 1'b1; smp_chan = ch; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R13 watchdog got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    rst_n = 1'b0; smp_valid = 1'b0; smp_chan = '0; smp_data = '0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state at the ports
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 mode_word", mode_word, 32'h0);
    check("R1 cfg_word", cfg_word, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [94:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("%s vec%0d", v[94:71], i);
      case (v[70:69])
        OP_W: bus_write(v[68:64], v[63:32]);
        OP_P: push(v[57:56], v[55:32]);
        default: begin
          bus_read(v[68:64], got);
          check(tag, got, v[31:0]);
        end
      endcase
    end
    check("R2 cfg_word port", cfg_word, 32'h00A5_0055);
    check("R2 mode_word port", mode_word, 32'h8000_0005);

    // R10: irq follows enabled ready flag, held until status read
    bus_read(A_STAT, got);
    check("R10 idle irq", {31'b0, irq}, 32'h0);
    push(2'd0, 24'hAAAAAA);
    check("R10 irq not yet latched", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R10 irq on ready", {31'b0, irq}, 32'h1);
    bus_read(A_HOLD, got);
    check("R4 hold after irq", got, 32'h00AA_AAAA);
    repeat (2) @(negedge clk);
    check("R10 irq held", {31'b0, irq}, 32'h1);
    bus_read(A_STAT, got);
    check("R8 sticky ready+empty", got, 32'h0000_0003);
    check("R10 irq cleared by read", {31'b0, irq}, 32'h0);

    // R6: overrun on a full queue
    bus_write(A_IDIS, 32'h1);
    bus_write(A_MODE, 32'h0000_0001);
    for (int i = 0; i < 16; i++) push(2'd0, 24'(i));
    bus_read(A_STAT, got);
    check("R10 no irq when full", {31'b0, irq}, 32'h0);
    push(2'd0, 24'hDEAD00);
    check("R6 irq on overrun", {31'b0, irq}, 32'h1);
    bus_read(A_STAT, got);
    check("R6 overrun flag", got, 32'h0000_002D);
    bus_read(A_STAT, got);
    check("R8 event reported once", got, 32'h0000_000D);

    // R6: push with a same-cycle holding read on a full queue
    smp_valid = 1'b1; smp_chan = 2'd0; smp_data = 24'h999999;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_HOLD;
    @(negedge clk);
    smp_valid = 1'b0; bus_sel = 1'b0;
    check("R6 head with simultaneous push", bus_rdata, 32'h0000_0000);
    bus_read(A_STAT, got);
    check("R6 no overrun on push+pop", got, 32'h0000_000D);

    // R8: overrun in the same cycle as a status read
    smp_valid = 1'b1; smp_chan = 2'd0; smp_data = 24'h555555;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_STAT;
    @(negedge clk);
    smp_valid = 1'b0; bus_sel = 1'b0;
    check("R8 coincident overrun seen", bus_rdata, 32'h0000_002D);
    bus_read(A_STAT, got);
    check("R8 coincident overrun not repeated", got, 32'h0000_000D);

    for (int i = 1; i < 16; i++) begin
      bus_read(A_HOLD, got);
      check("R4 drain order", got, 32'(i));
    end
    bus_read(A_HOLD, got);
    check("R6 accepted push kept", got, 32'h0099_9999);
    bus_read(A_HOLD, got);
    check("R5 empty read", got, 32'h0);
    repeat (3) @(negedge clk);
    check("R13 rdata held", bus_rdata, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule